// File: doc/BRIEF.md
# Byte-Lane Random Port with Register Window

This block is the random-access side of a dual-ported 16-bit word memory, modelled as a synchronous block. A single address, write-data and read/write bundle is shared between two targets. The memory array is selected by an active-low select strobe. A small bank of buffer-control registers is selected by a separate active-low command strobe. The registers are two start pointers, two end pointers, a control word and a read-only flag word. Their contents are exported every cycle to the sequential side of the memory, and the sequential side returns two end-of-buffer hit pulses that set the flags.

Array accesses are masked per byte lane by two active-low lane enables. Read data comes back one cycle after the request, with a per-lane valid in place of tri-state drivers. If both strobes are active in the same cycle, nothing is accessed and an error output is raised. The array depth is set by `ADDR_W`. The full configuration uses 13 address bits, giving 8192 words. The default elaboration uses 11 bits so that the model stays small.

Top module: `ramport_regwin`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `ra_rdata`=0, `ra_rvalid`=0, `ra_clash`=0. It also shows all exported pointers, `seq_ctrl` and `seq_flags` at 0.
- R2: An edge with `ra_sel_n`=0, `ra_cmd_n`=1 and `ra_rw`=0 writes the array at `ra_addr`. Bits 7:0 are written only if `ra_lb_n`=0, and bits 15:8 only if `ra_ub_n`=0. The other lane keeps its old contents.
- R3: An edge with `ra_sel_n`=0, `ra_cmd_n`=1, `ra_rw`=1 and `ra_oe_n`=0 reads the array. In the following cycle, `ra_rvalid[0]` and `ra_rvalid[1]` are the sampled inverses of `ra_lb_n` and `ra_ub_n`. Each enabled lane carries the stored byte, and each disabled lane reads 0.
- R4: When `ra_oe_n`=1 or `ra_rw`=0 at an edge, the next cycle has `ra_rvalid`=0 and `ra_rdata`=0.
- R5: An edge with `ra_cmd_n`=0, `ra_sel_n`=1 and `ra_rw`=0 stores `ra_wdata[12:0]` into the register chosen by `ra_addr[2:0]`. The codes are: 000 start pointer 1, 001 start pointer 2, 010 end pointer 1, 011 end pointer 2, 101 control. The new value appears on the matching `seq_*` output in the next cycle.
- R6: An edge with `ra_cmd_n`=0, `ra_sel_n`=1, `ra_rw`=1 and `ra_oe_n`=0 reads a register. In the next cycle, `ra_rvalid`=2'b11 regardless of the lane enables, and the value is zero-extended to 16 bits. Code 100 returns the flags in bits 1:0 (flag 1 in bit 0, flag 2 in bit 1). Codes 110 and 111 return 0. A write to code 100 or to an unused code changes nothing.
- R7: `eob_hit[i]` high at an edge sets `seq_flags[i]`. A control write with `ra_wdata[i]`=0 clears `seq_flags[i]`, and a write with that bit set to 1 leaves it alone. If a hit and a clearing write arrive together, the flag stays set.
- R8: When `ra_sel_n` and `ra_cmd_n` are both 0 at an edge, `ra_clash`=1 in the next cycle and `ra_rvalid`=0. Neither the array nor any register is written.
- R9: A register access never touches the array, even when `ra_addr` matches an array word. The address bits above bit 2 do not affect register decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_addr | input | ADDR_W | Word address; bits 2:0 select a register in the window |
| ra_wdata | input | 16 | Write data; bits 12:0 used for register writes |
| ra_rdata | output | 16 | Read data, one cycle after the request; disabled lanes read 0 |
| ra_rvalid | output | 2 | Per-lane read valid (bit 0 low byte, bit 1 high byte) |
| ra_sel_n | input | 1 | Active-low array select |
| ra_cmd_n | input | 1 | Active-low register window select |
| ra_rw | input | 1 | 1 read, 0 write |
| ra_oe_n | input | 1 | Active-low read output enable |
| ra_lb_n | input | 1 | Active-low low byte lane enable |
| ra_ub_n | input | 1 | Active-low high byte lane enable |
| eob_hit | input | 2 | End-of-buffer hit pulses from the sequential side |
| seq_start1 | output | REG_W | Start pointer 1 |
| seq_start2 | output | REG_W | Start pointer 2 |
| seq_end1 | output | REG_W | End pointer 1 |
| seq_end2 | output | REG_W | End pointer 2 |
| seq_ctrl | output | REG_W | Control word |
| seq_flags | output | 2 | End-of-buffer flags |
| ra_clash | output | 1 | Both strobes were active in the previous cycle |

## Verification
The array is exercised with full-word writes, single-lane writes over a known word, and single-lane reads. These separate a lane mask that leaks into the other byte from one that drops the enabled byte. Reads with the output enable high show whether data escapes without permission. Register traffic writes distinct values to every code and reads them back with both lane enables high, which tells apart a broken decode, a swapped pointer, and a read path wrongly gated by the lanes. Flag patterns pair hits with clearing, non-clearing and simultaneous control writes. Strobe clashes are followed by reads of the array word and registers they targeted, to prove that nothing was written.

// File: rtl/rpw_pkg.sv
// Shared types for the random port with register window.
// Assumes a 16-bit data path split into two byte lanes.
package rpw_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    // Register window codes on address bits 2:0.
    typedef enum logic [2:0] {
        RA_START1 = 3'b000,
        RA_START2 = 3'b001,
        RA_END1   = 3'b010,
        RA_END2   = 3'b011,
        RA_FLAGS  = 3'b100,
        RA_CTRL   = 3'b101
    } rpw_reg_e;

    // One cycle's decoded operation.
    typedef struct packed {
        logic arr_wr;
        logic arr_rd;
        logic reg_wr;
        logic reg_rd;
        logic clash;
    } rpw_op_t;

endpackage

// File: rtl/rpw_decode.sv
// Decodes the strobes into at most one operation per cycle.
// Assumes active-low strobes. Both strobes active yields only a clash.
module rpw_decode
    import rpw_pkg::*;
(
    input  logic    sel_n,
    input  logic    cmd_n,
    input  logic    rw,
    input  logic    oe_n,
    output rpw_op_t op
);

    // Purpose: map strobe combinations onto exclusive operations.
    always_comb begin
        op.clash  = !sel_n && !cmd_n;
        op.arr_wr = !sel_n &&  cmd_n && !rw;
        op.arr_rd = !sel_n &&  cmd_n &&  rw && !oe_n;
        op.reg_wr = !cmd_n &&  sel_n && !rw;
        op.reg_rd = !cmd_n &&  sel_n &&  rw && !oe_n;
    end

endmodule

// File: rtl/rpw_array.sv
// Byte-lane memory array with a registered read port.
// Assumes a single access per cycle. A disabled lane reads as zero with its valid low.
module rpw_array
    import rpw_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_en,
    input  logic              wr,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rvld
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        // Purpose: store this lane's byte when it is enabled for a write.
        always_ff @(posedge clk) begin
            if (wr && lane_en[g]) begin
                mem[addr] <= wdata[g*8 +: 8];
            end
        end

        // Purpose: register this lane's read byte and valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*8 +: 8] <= '0;
                rvld[g]         <= 1'b0;
            end else begin
                rvld[g]         <= rd && lane_en[g];
                rdata[g*8 +: 8] <= (rd && lane_en[g]) ? mem[addr] : 8'h00;
            end
        end

        // R3: a lane is valid only after a read with that lane enabled.
        assert_lane_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rvld[g] |-> $past(rd && lane_en[g]));

        // R3: a disabled lane never carries data.
        assert_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !rvld[g] |-> (rdata[g*8 +: 8] == 8'h00));
    end

endmodule

// File: rtl/rpw_regs.sv
// Buffer-control register bank: four pointers, a control word and two flags.
// Assumes writes and reads are never issued in the same cycle. Hits win over clears.
module rpw_regs
    import rpw_pkg::*;
#(
    parameter int REG_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        eob_hit,
    output logic [REG_W-1:0]  start1,
    output logic [REG_W-1:0]  start2,
    output logic [REG_W-1:0]  end1,
    output logic [REG_W-1:0]  end2,
    output logic [REG_W-1:0]  ctrl,
    output logic [1:0]        flags,
    output logic [DATA_W-1:0] rdata,
    output logic              rvld
);

    localparam int NPTR = 4;

    logic [REG_W-1:0] ptr_q [NPTR];
    logic [REG_W-1:0] rd_sel;
    logic             ctrl_wr;

    assign ctrl_wr = wr && (reg_addr == RA_CTRL);

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        // Purpose: hold one buffer pointer, loaded when its code is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[p] <= '0;
            end else if (wr && (reg_addr == 3'(p))) begin
                ptr_q[p] <= wdata;
            end
        end
    end

    // Purpose: hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= wdata;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_flag
        // Purpose: set a flag on a hit, clear it on a control write of zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (eob_hit[i]) begin
                flags[i] <= 1'b1;
            end else if (ctrl_wr && !wdata[i]) begin
                flags[i] <= 1'b0;
            end
        end

        // R7: a hit always leaves the flag set.
        assert_hit_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            eob_hit[i] |=> flags[i]);

        // R7: a clearing control write without a hit drops the flag.
        assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && !wdata[i] && !eob_hit[i]) |=> !flags[i]);
    end

    assign start1 = ptr_q[0];
    assign start2 = ptr_q[1];
    assign end1   = ptr_q[2];
    assign end2   = ptr_q[3];

    // Purpose: select the register addressed for a read.
    always_comb begin
        case (rpw_reg_e'(reg_addr))
            RA_START1, RA_START2, RA_END1, RA_END2: rd_sel = ptr_q[reg_addr[1:0]];
            RA_FLAGS: rd_sel = {{(REG_W-2){1'b0}}, flags};
            RA_CTRL:  rd_sel = ctrl;
            default:  rd_sel = '0;
        endcase
    end

    // Purpose: register the read value, zero-extended to the data width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            rvld  <= 1'b0;
        end else begin
            rvld  <= rd;
            rdata <= rd ? {{(DATA_W-REG_W){1'b0}}, rd_sel} : '0;
        end
    end

    // R6: register read data never has bits above the register width.
    assert_reg_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:REG_W] == '0);

endmodule

// File: rtl/ramport_regwin.sv
// Top: random port that shares address and data between a byte-lane array
// and a buffer-control register window. Assumes strobes are sampled on the
// clock. Output enable is treated as a synchronous read qualifier.
module ramport_regwin
    import rpw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int REG_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [15:0]       ra_wdata,
    output logic [15:0]       ra_rdata,
    output logic [1:0]        ra_rvalid,
    input  logic              ra_sel_n,
    input  logic              ra_cmd_n,
    input  logic              ra_rw,
    input  logic              ra_oe_n,
    input  logic              ra_lb_n,
    input  logic              ra_ub_n,
    input  logic [1:0]        eob_hit,
    output logic [REG_W-1:0]  seq_start1,
    output logic [REG_W-1:0]  seq_start2,
    output logic [REG_W-1:0]  seq_end1,
    output logic [REG_W-1:0]  seq_end2,
    output logic [REG_W-1:0]  seq_ctrl,
    output logic [1:0]        seq_flags,
    output logic              ra_clash
);

    rpw_op_t           op;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] arr_rdata;
    logic [LANES-1:0]  arr_rvld;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_rvld;

    assign lane_en = {!ra_ub_n, !ra_lb_n};

    rpw_decode u_decode (
        .sel_n (ra_sel_n),
        .cmd_n (ra_cmd_n),
        .rw    (ra_rw),
        .oe_n  (ra_oe_n),
        .op    (op)
    );

    rpw_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (ra_addr),
        .wdata   (ra_wdata),
        .lane_en (lane_en),
        .wr      (op.arr_wr),
        .rd      (op.arr_rd),
        .rdata   (arr_rdata),
        .rvld    (arr_rvld)
    );

    rpw_regs #(.REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (ra_addr[2:0]),
        .wdata    (ra_wdata[REG_W-1:0]),
        .wr       (op.reg_wr),
        .rd       (op.reg_rd),
        .eob_hit  (eob_hit),
        .start1   (seq_start1),
        .start2   (seq_start2),
        .end1     (seq_end1),
        .end2     (seq_end2),
        .ctrl     (seq_ctrl),
        .flags    (seq_flags),
        .rdata    (reg_rdata),
        .rvld     (reg_rvld)
    );

    // Purpose: register the strobe clash for the error output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_clash <= 1'b0;
        end else begin
            ra_clash <= op.clash;
        end
    end

    // Both read sources are zero when idle, so they merge by OR.
    assign ra_rdata  = arr_rdata | reg_rdata;
    assign ra_rvalid = arr_rvld | {LANES{reg_rvld}};

    // R8: a clash produces no read data.
    assert_clash_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ra_clash |-> (ra_rvalid == '0));

    // R8: a clash leaves every software-written register unchanged.
    assert_clash_noreg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_sel_n && !ra_cmd_n) |=> ($stable(seq_start1) && $stable(seq_start2) &&
                                      $stable(seq_end1) && $stable(seq_end2) &&
                                      $stable(seq_ctrl)));

    // R4: without output enable there is no read result.
    assert_oe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_oe_n || !ra_rw) |=> (ra_rvalid == '0 && ra_rdata == '0));

    // R6: a register read is valid on both lanes whatever the lane enables.
    assert_reg_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_cmd_n && ra_sel_n && ra_rw && !ra_oe_n) |=> (ra_rvalid == 2'b11));

endmodule

// File: tb/sim_ramport_regwin.sv
// Scoreboard bench: the driver computes expected results from a model and
// queues them; the monitor pops and compares one cycle after each request.
module sim_ramport_regwin;

    localparam int AW = 11;
    localparam int RW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ra_addr = '0;
    logic [15:0]   ra_wdata = '0;
    logic [15:0]   ra_rdata;
    logic [1:0]    ra_rvalid;
    logic          ra_sel_n = 1'b1, ra_cmd_n = 1'b1, ra_rw = 1'b1, ra_oe_n = 1'b1;
    logic          ra_lb_n = 1'b1, ra_ub_n = 1'b1;
    logic [1:0]    eob_hit = '0;
    logic [RW-1:0] seq_start1, seq_start2, seq_end1, seq_end2, seq_ctrl;
    logic [1:0]    seq_flags;
    logic          ra_clash;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [15:0] d;
        logic [1:0]  v;
        logic        e;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [15:0]   mm [1 << AW];
    logic [RW-1:0] rm [8];
    logic [1:0]    fl;

    always #5 clk = ~clk;

    ramport_regwin #(.ADDR_W(AW), .REG_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .ra_addr(ra_addr), .ra_wdata(ra_wdata),
        .ra_rdata(ra_rdata), .ra_rvalid(ra_rvalid), .ra_sel_n(ra_sel_n),
        .ra_cmd_n(ra_cmd_n), .ra_rw(ra_rw), .ra_oe_n(ra_oe_n), .ra_lb_n(ra_lb_n),
        .ra_ub_n(ra_ub_n), .eob_hit(eob_hit), .seq_start1(seq_start1),
        .seq_start2(seq_start2), .seq_end1(seq_end1), .seq_end2(seq_end2),
        .seq_ctrl(seq_ctrl), .seq_flags(seq_flags), .ra_clash(ra_clash)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", what, got, exp);
        end
    endtask

    // Drive one request at a falling edge and queue its expected result.
    task automatic op(input logic sel_n, input logic cmd_n, input logic rw,
                      input logic oe_n, input logic lb_n, input logic ub_n,
                      input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [1:0] hit, input string tag);
        exp_t e;
        ra_sel_n = sel_n; ra_cmd_n = cmd_n; ra_rw = rw; ra_oe_n = oe_n;
        ra_lb_n = lb_n; ra_ub_n = ub_n; ra_addr = a; ra_wdata = d; eob_hit = hit;
        e.d = '0; e.v = '0; e.e = !sel_n && !cmd_n; e.tag = tag;
        if (!e.e && !sel_n && rw && !oe_n) begin
            e.v = {!ub_n, !lb_n};
            e.d = {ub_n ? 8'h00 : mm[a][15:8], lb_n ? 8'h00 : mm[a][7:0]};
        end else if (!e.e && !cmd_n && rw && !oe_n) begin
            e.v = 2'b11;
            case (a[2:0])
                3'd0, 3'd1, 3'd2, 3'd3, 3'd5: e.d = {3'b000, rm[a[2:0]]};
                3'd4: e.d = {14'd0, fl};
                default: e.d = '0;
            endcase
        end
        if (!e.e && !sel_n && !rw) begin
            if (!lb_n) mm[a][7:0]  = d[7:0];
            if (!ub_n) mm[a][15:8] = d[15:8];
        end
        for (int i = 0; i < 2; i++) begin
            if (hit[i]) fl[i] = 1'b1;
            else if (!e.e && !cmd_n && !rw && a[2:0] == 3'd5 && !d[i]) fl[i] = 1'b0;
        end
        if (!e.e && !cmd_n && !rw && a[2:0] != 3'd4 && a[2:0] < 3'd6) rm[a[2:0]] = d[RW-1:0];
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, 2'b00, "idle R4");
    endtask

    // Monitor: compare each cycle's result with the oldest queued item.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (ra_rdata !== e.d || ra_rvalid !== e.v || ra_clash !== e.e) begin
                    fails++;
                    $display("FAIL %s: actual d=%h v=%b err=%b expected d=%h v=%b err=%b",
                             e.tag, ra_rdata, ra_rvalid, ra_clash, e.d, e.v, e.e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        fl = '0;
        for (int i = 0; i < 8; i++) rm[i] = '0;
        repeat (3) @(negedge clk);
        chk({16'd0, ra_rdata}, 32'd0, "R1 rdata");
        chk({30'd0, ra_rvalid}, 32'd0, "R1 rvalid");
        chk({31'd0, ra_clash}, 32'd0, "R1 clash");
        chk({19'd0, seq_start1 | seq_start2 | seq_end1 | seq_end2 | seq_ctrl}, 32'd0, "R1 regs");
        chk({30'd0, seq_flags}, 32'd0, "R1 flags");
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: full word, then a single-lane overwrite, then lane reads.
        op(0, 1, 0, 1, 0, 0, 11'h005, 16'h1234, 2'b00, "R2 write full");
        op(0, 1, 0, 1, 0, 0, 11'h7F8, 16'hBEEF, 2'b00, "R2 write far");
        op(0, 1, 1, 0, 0, 0, 11'h005, 16'h0000, 2'b00, "R3 read full");
        op(0, 1, 0, 1, 0, 1, 11'h005, 16'hAAAA, 2'b00, "R2 write low lane");
        op(0, 1, 0, 1, 1, 0, 11'h7F8, 16'h55CC, 2'b00, "R2 write high lane");
        op(0, 1, 1, 0, 0, 0, 11'h005, 16'h0000, 2'b00, "R2 read after low lane");
        op(0, 1, 1, 0, 0, 0, 11'h7F8, 16'h0000, 2'b00, "R2 read after high lane");
        op(0, 1, 1, 0, 1, 0, 11'h005, 16'h0000, 2'b00, "R3 read high only");
        op(0, 1, 1, 0, 0, 1, 11'h7F8, 16'h0000, 2'b00, "R3 read low only");
        op(0, 1, 1, 1, 0, 0, 11'h005, 16'h0000, 2'b00, "R4 read oe high");
        idle();

        // R5: load every register; upper data bits must be dropped.
        op(1, 0, 0, 1, 1, 1, 11'h000, 16'hE011, 2'b00, "R5 start1");
        chk({19'd0, seq_start1}, 32'h0011, "R5 start1 export");
        op(1, 0, 0, 1, 1, 1, 11'h001, 16'h0222, 2'b00, "R5 start2");
        op(1, 0, 0, 1, 1, 1, 11'h002, 16'h0333, 2'b00, "R5 end1");
        op(1, 0, 0, 1, 1, 1, 11'h003, 16'h1FFF, 2'b00, "R5 end2");
        op(1, 0, 0, 1, 1, 1, 11'h005, 16'h0ABF, 2'b00, "R5 ctrl");
        chk({19'd0, seq_start2}, 32'h0222, "R5 start2 export");
        chk({19'd0, seq_end1}, 32'h0333, "R5 end1 export");
        chk({19'd0, seq_end2}, 32'h1FFF, "R5 end2 export");
        chk({19'd0, seq_ctrl}, 32'h0ABF, "R5 ctrl export");

        // R6: read back with lane enables off; flag, unused codes, ignored writes.
        for (int c = 0; c < 8; c++) op(1, 0, 1, 0, 1, 1, AW'(c), 16'h0, 2'b00, "R6 reg read");
        op(1, 0, 0, 1, 1, 1, 11'h004, 16'h1FFF, 2'b00, "R6 flag write ignored");
        op(1, 0, 0, 1, 1, 1, 11'h006, 16'h1FFF, 2'b00, "R6 unused write ignored");
        op(1, 0, 1, 0, 0, 0, 11'h004, 16'h0, 2'b00, "R6 flag read");
        op(1, 0, 1, 0, 0, 0, 11'h006, 16'h0, 2'b00, "R6 unused read");
        chk({30'd0, seq_flags}, 32'd0, "R6 flags unchanged");

        // R7: set, selective clear, set wins over clear.
        op(1, 1, 1, 1, 1, 1, 11'h0, 16'h0, 2'b11, "R7 hit both");
        chk({30'd0, seq_flags}, 32'd3, "R7 set by hits");
        op(1, 0, 1, 0, 1, 1, 11'h004, 16'h0, 2'b00, "R7 flag read set");
        op(1, 0, 0, 1, 1, 1, 11'h005, 16'h0002, 2'b00, "R7 clear flag 1");
        chk({30'd0, seq_flags}, 32'd2, "R7 bit0 zero clears flag 1");
        op(1, 0, 0, 1, 1, 1, 11'h005, 16'h0000, 2'b10, "R7 hit beats clear");
        chk({30'd0, seq_flags}, 32'd2, "R7 hit wins");
        op(1, 0, 0, 1, 1, 1, 11'h005, 16'h0001, 2'b00, "R7 clear flag 2");
        chk({30'd0, seq_flags}, 32'd0, "R7 bit1 zero clears flag 2");

        // R8: clash writes and reads nothing.
        op(0, 0, 0, 1, 0, 0, 11'h005, 16'hFFFF, 2'b00, "R8 clash write");
        op(0, 0, 1, 0, 0, 0, 11'h000, 16'h0, 2'b00, "R8 clash read");
        chk({19'd0, seq_ctrl}, 32'h0001, "R8 ctrl kept");
        op(0, 1, 1, 0, 0, 0, 11'h005, 16'h0, 2'b00, "R8 array kept");
        op(1, 0, 1, 0, 0, 0, 11'h000, 16'h0, 2'b00, "R8 start1 kept");

        // R9: register write at an address that maps to an array word.
        op(1, 0, 0, 1, 0, 0, 11'h7F8, 16'h0777, 2'b00, "R9 reg write high addr");
        chk({19'd0, seq_start1}, 32'h0777, "R9 upper address ignored");
        op(0, 1, 1, 0, 0, 0, 11'h7F8, 16'h0, 2'b00, "R9 array untouched");
        idle();
        idle();
        chk(q.size(), 32'd0, "R3 scoreboard drained");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule